// File: doc/BRIEF.md
# Attribute Controller Index/Data Port

This block sits behind one write address of a display controller and sorts the bytes arriving there into index bytes and data bytes. A toggle inside the block decides which one each write is. The first write after reset is an index. The next is data, and the pattern keeps alternating. Software cannot see the toggle directly. To bring it back to the index phase, software reads a separate status address. That read also returns the vertical retrace and display-enable flags.

The index byte carries two things: a register number, and a bit that switches the pixel stream on. While that bit is clear, the pixel output carries a fixed blank colour. Two registers are implemented. The mode register drives a graphics-mode output and a wide-pixel (one byte per pixel) output. The pan register drives the horizontal pixel shift amount. A third address reads back the register selected by the index. Reading the write address returns the index byte itself.

Top module: `attr_ctrl_port`

## Requirements
- R1: The first write to the port address after reset is taken as an index byte. Later writes to that address alternate between data and index.
- R2: A read of the status address forces the next port write to be taken as an index byte, whichever phase the toggle was in.
- R3: An index write stores bits [4:0] as the register number and bit 5 as the video enable. A lone index write of 0x20 turns video on again.
- R4: A data write to register 0x10 stores the byte. Bit 0 drives `gfx_mode_o` and bit 6 drives `wide_pix_o`, from the clock edge that takes the write.
- R5: A data write to register 0x13 stores its low `PAN_W` bits, which drive `pan_o`. A pan of zero means no shift.
- R6: A data write to any other register number changes nothing. A readback of such a register number returns 0x00.
- R7: While the video enable is 0, `pix_o` is `BLANK`. While it is 1, `pix_o` is `pix_i` delayed by one clock.
- R8: A status read returns `vretrace_i` in bit 3 and `disp_en_i` in bit 0, with every other bit at zero.
- R9: The result of a read appears on `bus_rdata` one clock after the read. A read of the data address returns the selected register, zero-extended. A read of the port address returns the index byte: the register number in bits [4:0] and the enable in bit 5.
- R10: Reset clears the toggle to the index phase, the register number, the enable, both registers and the read data. The pixel output is therefore blank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Access address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| vretrace_i | input | 1 | Vertical retrace flag for status reads |
| disp_en_i | input | 1 | Display-enable flag for status reads |
| pix_i | input | PIX_W | Pixel colour from the pixel path |
| pix_o | output | PIX_W | Gated pixel colour |
| gfx_mode_o | output | 1 | Graphics mode select |
| wide_pix_o | output | 1 | Wide pixel (256-colour) select |
| pan_o | output | PAN_W | Horizontal pixel pan amount |

## Verification
The assertions assume that a read strobe and a write strobe never arrive in the same cycle. If they did, a status read and a port write would both act on the toggle, and the alternation property would no longer describe the outcome. The stimulus drives each access as a single-cycle strobe. Every access is followed by an idle cycle, and read and write are never raised together. The retrace and display-enable inputs change only between accesses.

// File: rtl/attr_pkg.sv
package attr_pkg;

    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    localparam int IDX_W         = 5;
    localparam int BYTE_W        = 8;
    localparam int IDX_EN_BIT    = 5;
    localparam int MODE_GFX_BIT  = 0;
    localparam int MODE_WIDE_BIT = 6;
    localparam int STAT_VR_BIT   = 3;
    localparam int STAT_DE_BIT   = 0;

    localparam logic [IDX_W-1:0] IDX_MODE = 5'h10;
    localparam logic [IDX_W-1:0] IDX_PAN  = 5'h13;

endpackage

// File: rtl/attr_seq.sv
module attr_seq
    import attr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_wr,
    input  logic              stat_rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic              phase_data,
    output logic [IDX_W-1:0]  idx,
    output logic              vid_en,
    output logic              data_wr
);

    typedef struct packed {
        phase_e           ph;
        logic [IDX_W-1:0] idx;
        logic             en;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (port_wr) begin
            if (s_q.ph == PH_INDEX) begin
                s_d.idx = wdata[IDX_W-1:0];
                s_d.en  = wdata[IDX_EN_BIT];
                s_d.ph  = PH_DATA;
            end else begin
                s_d.ph  = PH_INDEX;
            end
        end
        if (stat_rd) begin
            s_d.ph = PH_INDEX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_INDEX, idx: '0, en: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_data = (s_q.ph == PH_DATA);
    assign idx        = s_q.idx;
    assign vid_en     = s_q.en;
    assign data_wr    = port_wr && (s_q.ph == PH_DATA);

endmodule

// File: rtl/attr_regs.sv
module attr_regs
    import attr_pkg::*;
#(
    parameter int PAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] mode,
    output logic [PAN_W-1:0]  pan,
    output logic [BYTE_W-1:0] rd_val
);

    typedef struct packed {
        logic [BYTE_W-1:0] mode;
        logic [PAN_W-1:0]  pan;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (data_wr) begin
            case (idx)
                IDX_MODE: r_d.mode = wdata;
                IDX_PAN:  r_d.pan  = wdata[PAN_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_val = '0;
        case (idx)
            IDX_MODE: rd_val = r_q.mode;
            IDX_PAN:  rd_val[PAN_W-1:0] = r_q.pan;
            default:  rd_val = '0;
        endcase
    end

    assign mode = r_q.mode;
    assign pan  = r_q.pan;

endmodule

// File: rtl/attr_pixgate.sv
module attr_pixgate #(
    parameter int             PIX_W = 8,
    parameter logic [PIX_W-1:0] BLANK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PIX_W-1:0] pix_i,
    output logic [PIX_W-1:0] pix_o
);

    logic [PIX_W-1:0] pix_d, pix_q;

    always_comb begin
        pix_d = en ? pix_i : BLANK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q <= BLANK;
        end else begin
            pix_q <= pix_d;
        end
    end

    assign pix_o = pix_q;

endmodule

// File: rtl/attr_ctrl_port.sv
module attr_ctrl_port
    import attr_pkg::*;
#(
    parameter int                ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR    = 16'h03C0,
    parameter logic [ADDR_W-1:0] DATA_RD_ADDR = 16'h03C1,
    parameter logic [ADDR_W-1:0] STAT_ADDR    = 16'h03DA,
    parameter int                PAN_W        = 4,
    parameter int                PIX_W        = 8,
    parameter logic [PIX_W-1:0]  BLANK        = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              vretrace_i,
    input  logic              disp_en_i,
    input  logic [PIX_W-1:0]  pix_i,
    output logic [PIX_W-1:0]  pix_o,
    output logic              gfx_mode_o,
    output logic              wide_pix_o,
    output logic [PAN_W-1:0]  pan_o
);

    logic              port_wr;
    logic              stat_rd;
    logic              data_wr;
    logic              phase_data;
    logic              vid_en;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] mode;
    logic [BYTE_W-1:0] reg_val;
    logic [BYTE_W-1:0] rdata_d, rdata_q;
    logic [BYTE_W-1:0] stat_byte, idx_byte;

    assign port_wr = bus_wr && (bus_addr == PORT_ADDR);
    assign stat_rd = bus_rd && (bus_addr == STAT_ADDR);

    attr_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_wr    (port_wr),
        .stat_rd    (stat_rd),
        .wdata      (bus_wdata),
        .phase_data (phase_data),
        .idx        (idx),
        .vid_en     (vid_en),
        .data_wr    (data_wr)
    );

    attr_regs #(.PAN_W(PAN_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_wr (data_wr),
        .idx     (idx),
        .wdata   (bus_wdata),
        .mode    (mode),
        .pan     (pan_o),
        .rd_val  (reg_val)
    );

    attr_pixgate #(.PIX_W(PIX_W), .BLANK(BLANK)) i_pix (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (vid_en),
        .pix_i (pix_i),
        .pix_o (pix_o)
    );

    always_comb begin
        stat_byte = '0;
        stat_byte[STAT_VR_BIT] = vretrace_i;
        stat_byte[STAT_DE_BIT] = disp_en_i;
        idx_byte = '0;
        idx_byte[IDX_W-1:0]  = idx;
        idx_byte[IDX_EN_BIT] = vid_en;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd) begin
            if (bus_addr == STAT_ADDR) begin
                rdata_d = stat_byte;
            end else if (bus_addr == DATA_RD_ADDR) begin
                rdata_d = reg_val;
            end else if (bus_addr == PORT_ADDR) begin
                rdata_d = idx_byte;
            end else begin
                rdata_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata  = rdata_q;
    assign gfx_mode_o = mode[MODE_GFX_BIT];
    assign wide_pix_o = mode[MODE_WIDE_BIT];

endmodule

// File: rtl/attr_ctrl_port_chk.sv
module attr_ctrl_port_chk #(
    parameter int               PAN_W = 4,
    parameter int               PIX_W = 8,
    parameter logic [PIX_W-1:0] BLANK = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             port_wr,
    input logic             stat_rd,
    input logic             data_wr,
    input logic             phase_data,
    input logic             vid_en,
    input logic [PIX_W-1:0] pix_o,
    input logic             gfx_mode_o,
    input logic             wide_pix_o,
    input logic [PAN_W-1:0] pan_o
);

    // R1: every port write flips the toggle
    a_r1_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr && !stat_rd |=> phase_data != $past(phase_data));

    // R2: a status read leaves the toggle in the index phase
    a_r2_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !phase_data);

    // R2: input assumption, no read and write in one cycle
    a_r2_no_collide: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R4: mode outputs hold without a data write
    a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable(gfx_mode_o) && $stable(wide_pix_o));

    // R5: pan holds without a data write
    a_r5_pan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable(pan_o));

    // R7: disabled video gives the blank colour
    a_r7_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_en |=> pix_o == BLANK);

endmodule

bind attr_ctrl_port attr_ctrl_port_chk #(
    .PAN_W (PAN_W),
    .PIX_W (PIX_W),
    .BLANK (BLANK)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .port_wr    (port_wr),
    .stat_rd    (stat_rd),
    .data_wr    (data_wr),
    .phase_data (phase_data),
    .vid_en     (vid_en),
    .pix_o      (pix_o),
    .gfx_mode_o (gfx_mode_o),
    .wide_pix_o (wide_pix_o),
    .pan_o      (pan_o)
);

// File: tb/test_attr_ctrl_port.sv
module test_attr_ctrl_port;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_PORT = 16'h03C0;
    localparam logic [15:0] A_DATA = 16'h03C1;
    localparam logic [15:0] A_STAT = 16'h03DA;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RS = 2'd1;
    localparam logic [1:0] OP_RD = 2'd2;
    localparam logic [1:0] OP_RI = 2'd3;

    // {op, wdata, check, expected}
    localparam int NV = 16;
    localparam logic [18:0] VEC [NV] = '{
        {OP_RI, 8'h00, 1'b1, 8'h00},
        {OP_WR, 8'h30, 1'b0, 8'h00},
        {OP_RI, 8'h00, 1'b1, 8'h30},
        {OP_WR, 8'h41, 1'b0, 8'h00},
        {OP_RD, 8'h00, 1'b1, 8'h41},
        {OP_WR, 8'h33, 1'b0, 8'h00},
        {OP_WR, 8'h05, 1'b0, 8'h00},
        {OP_RD, 8'h00, 1'b1, 8'h05},
        {OP_WR, 8'h15, 1'b0, 8'h00},
        {OP_WR, 8'hAA, 1'b0, 8'h00},
        {OP_RD, 8'h00, 1'b1, 8'h00},
        {OP_RI, 8'h00, 1'b1, 8'h15},
        {OP_WR, 8'h13, 1'b0, 8'h00},
        {OP_RS, 8'h00, 1'b1, 8'h00},
        {OP_WR, 8'h33, 1'b0, 8'h00},
        {OP_RI, 8'h00, 1'b1, 8'h33}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        vretrace_i = 1'b0;
    logic        disp_en_i = 1'b0;
    logic [7:0]  pix_i = '0;
    logic [7:0]  pix_o;
    logic        gfx_mode_o;
    logic        wide_pix_o;
    logic [3:0]  pan_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    attr_ctrl_port i_attr_ctrl_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .vretrace_i (vretrace_i),
        .disp_en_i  (disp_en_i),
        .pix_i      (pix_i),
        .pix_o      (pix_o),
        .gfx_mode_o (gfx_mode_o),
        .wide_pix_o (wide_pix_o),
        .pan_o      (pan_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [7:0] wd);
        @(negedge clk);
        case (op)
            OP_WR: begin bus_addr = A_PORT; bus_wr = 1'b1; bus_wdata = wd; end
            OP_RS: begin bus_addr = A_STAT; bus_rd = 1'b1; end
            OP_RD: begin bus_addr = A_DATA; bus_rd = 1'b1; end
            default: begin bus_addr = A_PORT; bus_rd = 1'b1; end
        endcase
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 pan", {4'h0, pan_o}, 8'h00);
        check("R10 mode", {6'h0, wide_pix_o, gfx_mode_o}, 8'h00);
        check("R10 pix", pix_o, 8'h00);
        rst_n = 1'b1;

        // table: R1 R3 R4 R5 R6 R9, status clear R2
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][18:17], VEC[i][16:9]);
            if (VEC[i][8]) check($sformatf("R1/R2/R6/R9 vec %0d", i), bus_rdata, VEC[i][7:0]);
        end

        // R4, R5: outputs from stored registers
        check("R4 gfx", {7'h0, gfx_mode_o}, 8'h01);
        check("R4 wide", {7'h0, wide_pix_o}, 8'h01);
        check("R5 pan", {4'h0, pan_o}, 8'h05);

        // R7: enabled video passes pixels one clock later
        pix_i = 8'h5A;
        @(negedge clk);
        @(negedge clk);
        check("R7 pass", pix_o, 8'h5A);

        // R7: index with enable clear blanks output
        do_op(OP_RS, 8'h00);
        do_op(OP_WR, 8'h13);
        @(negedge clk);
        check("R7 blank", pix_o, 8'h00);

        // R3: lone 0x20 re-enables video
        do_op(OP_RS, 8'h00);
        do_op(OP_WR, 8'h20);
        @(negedge clk);
        check("R3 reenable", pix_o, 8'h5A);
        do_op(OP_RI, 8'h00);
        check("R3 index byte", bus_rdata, 8'h20);

        // R8: status flags
        vretrace_i = 1'b1; disp_en_i = 1'b1;
        do_op(OP_RS, 8'h00);
        check("R8 both", bus_rdata, 8'h09);
        vretrace_i = 1'b1; disp_en_i = 1'b0;
        do_op(OP_RS, 8'h00);
        check("R8 retrace", bus_rdata, 8'h08);
        vretrace_i = 1'b0; disp_en_i = 1'b1;
        do_op(OP_RS, 8'h00);
        check("R8 de", bus_rdata, 8'h01);
        vretrace_i = 1'b0; disp_en_i = 1'b0;

        // R2: status read between index and data
        do_op(OP_WR, 8'h30);
        do_op(OP_RS, 8'h00);
        do_op(OP_WR, 8'h33);
        do_op(OP_RI, 8'h00);
        check("R2 clear mid", bus_rdata, 8'h33);
        check("R2 mode kept", {6'h0, wide_pix_o, gfx_mode_o}, 8'h03);

        // R10: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mode again", {6'h0, wide_pix_o, gfx_mode_o}, 8'h00);
        check("R10 pan again", {4'h0, pan_o}, 8'h00);
        check("R10 pix again", pix_o, 8'h00);
        rst_n = 1'b1;

        // R1: first write after reset is an index
        do_op(OP_WR, 8'h33);
        do_op(OP_RI, 8'h00);
        check("R1 first index", bus_rdata, 8'h33);
        do_op(OP_WR, 8'h07);
        check("R5 pan write", {4'h0, pan_o}, 8'h07);
        do_op(OP_RD, 8'h00);
        check("R9 pan readback", bus_rdata, 8'h07);
        do_op(OP_WR, 8'h10);
        do_op(OP_WR, 8'h00);
        check("R5 zero pan kept", {4'h0, pan_o}, 8'h07);
        check("R4 mode clear", {6'h0, wide_pix_o, gfx_mode_o}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule